// File: doc/BRIEF.md
# Dual-Mode SCL Period Generator

This block derives the serial clock timing for a two-wire bus master from the peripheral clock. Two configuration bytes carry an 11-bit divisor, an enable bit and a speed-select bit. From them the block produces a level that tells the pad to pull SCL low, plus single-cycle strobes at the start of the low phase, at the middle of the low phase (the point where the byte engine may change SDA) and at the start of the high phase. A separate byte holds a coarse code for the peripheral-clock range, which downstream bus-timing logic reads.

Standard speed uses equal low and high phases. Fast speed uses a 3/2 scaling of the period with a long low phase and a shorter high phase. The byte engine can hold the high phase while a slave stretches SCL. All configuration is sampled only when a new period begins, so a change never cuts a phase short.

Top module: `scl_period_gen`

## Requirements
- R1: The divisor is {ext_byte[5:0], ctl_byte[4:0]}. N is the divisor plus one. ctl_byte[5] is the enable and ctl_byte[6] selects fast speed (1) or standard speed (0).
- R2: At standard speed the low phase lasts N+1 clocks and the high phase lasts N+1 clocks.
- R3: At fast speed the low phase lasts N clocks and the high phase lasts ceil(N/2)+2 clocks.
- R4: When the enable is 0, the clock after it is sampled shows scl_drive_low at 0 and no strobe, and this lasts as long as the enable stays 0.
- R5: scl_drive_low is 1 for every cycle of the low phase. tick_low fires in the first low cycle and tick_high fires in the first high cycle. The first period begins one clock after the enable is seen high.
- R6: tick_mid fires in low-phase cycle floor(L/2), counted from 0, where L is the low-phase length.
- R7: While hold_in is 1 during the high phase, the high-phase count is frozen, so each held cycle lengthens the high phase by one clock.
- R8: The divisor and speed select are sampled only when a low phase starts. A change made during a period alters the next period and not the current one.
- R9: When freq_load is 1, freq_byte is stored and appears on range_code in the next cycle. Otherwise range_code keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_byte | input | 8 | Divisor low bits [4:0], enable [5], fast select [6] |
| ext_byte | input | 8 | Divisor high bits in [5:0] |
| freq_byte | input | 8 | Peripheral-clock range code to store |
| freq_load | input | 1 | Stores freq_byte |
| hold_in | input | 1 | Freezes the high phase while SCL is stretched |
| scl_drive_low | output | 1 | 1 while SCL must be pulled low |
| tick_low | output | 1 | First cycle of the low phase |
| tick_mid | output | 1 | Data-change point in the low phase |
| tick_high | output | 1 | First cycle of the high phase |
| range_code | output | 8 | Stored range code |

## Verification
The properties assume that hold_in is only raised by a byte engine that sees SCL released, so it matters only in the high phase. They also assume that the configuration bytes are steady inputs that may change on any cycle. The bench changes hold_in only in observed high cycles. It changes configuration either with the enable low or in the middle of a low phase, which tests the sampling rule of R8 without driving anything outside these assumptions.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_phase_calc.sv
// Combinational phase lengths from divisor and speed select.
module scl_phase_calc #(
  parameter int DIV_W = 11,
  parameter int CNT_W = DIV_W + 1
) (
  input  logic [DIV_W-1:0] div_val,
  input  logic             fast_sel,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] mid_pos
);
  logic [CNT_W-1:0] n_val;

  always_comb begin
    n_val = CNT_W'(div_val) + CNT_W'(1);
    if (fast_sel) begin
      low_len  = n_val;
      high_len = ((n_val + CNT_W'(1)) >> 1) + CNT_W'(2);
    end else begin
      low_len  = n_val + CNT_W'(1);
      high_len = n_val + CNT_W'(1);
    end
    mid_pos = low_len >> 1;
  end
endmodule

// File: rtl/scl_phase_ctr.sv
// Phase sequencer: latches lengths at each period start.
module scl_phase_ctr
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic [CNT_W-1:0] low_in,
  input  logic [CNT_W-1:0] high_in,
  input  logic [CNT_W-1:0] mid_in,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cur_low,
  output logic             drive_low,
  output logic             strb_low,
  output logic             strb_mid,
  output logic             strb_high
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] low_q, high_q, mid_q;
  logic             cfg_load;
  logic             hentry_q, hentry_d;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    cfg_load = 1'b0;
    if (!en) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_LOW;
          cnt_d    = '0;
          cfg_load = 1'b1;
        end
        PH_LOW: begin
          if (cnt_q == low_q - CNT_W'(1)) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (!hold) begin
            if (cnt_q == high_q - CNT_W'(1)) begin
              phase_d  = PH_LOW;
              cnt_d    = '0;
              cfg_load = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
    hentry_d = (phase_q == PH_LOW) && (phase_d == PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      hentry_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      hentry_q <= hentry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
      mid_q  <= '0;
    end else if (cfg_load) begin
      low_q  <= low_in;
      high_q <= high_in;
      mid_q  <= mid_in;
    end
  end

  assign phase     = phase_q;
  assign cnt       = cnt_q;
  assign cur_low   = low_q;
  assign drive_low = (phase_q == PH_LOW);
  assign strb_low  = (phase_q == PH_LOW) && (cnt_q == '0);
  assign strb_mid  = (phase_q == PH_LOW) && (cnt_q == mid_q);
  assign strb_high = hentry_q;
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int LO_BITS = 5,
  parameter int HI_BITS = 6,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] ctl_byte,
  input  logic [BYTE_W-1:0] ext_byte,
  input  logic [BYTE_W-1:0] freq_byte,
  input  logic              freq_load,
  input  logic              hold_in,
  output logic              scl_drive_low,
  output logic              tick_low,
  output logic              tick_mid,
  output logic              tick_high,
  output logic [BYTE_W-1:0] range_code
);
  localparam int DIV_W  = LO_BITS + HI_BITS;
  localparam int CNT_W  = DIV_W + 1;
  localparam int EN_BIT = LO_BITS;
  localparam int FM_BIT = LO_BITS + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [DIV_W-1:0]  div_val;
  logic [CNT_W-1:0]  low_len, high_len, mid_pos;
  logic [CNT_W-1:0]  cnt_w, cur_low_w;
  phase_e            phase_w;
  logic [BYTE_W-1:0] range_q;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign div_val = {ext_byte[HI_BITS-1:0], ctl_byte[LO_BITS-1:0]};

  scl_phase_calc #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_calc (
    .div_val  (div_val),
    .fast_sel (ctl_byte[FM_BIT]),
    .low_len  (low_len),
    .high_len (high_len),
    .mid_pos  (mid_pos)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (ctl_byte[EN_BIT]),
    .hold      (hold_in),
    .low_in    (low_len),
    .high_in   (high_len),
    .mid_in    (mid_pos),
    .phase     (phase_w),
    .cnt       (cnt_w),
    .cur_low   (cur_low_w),
    .drive_low (scl_drive_low),
    .strb_low  (tick_low),
    .strb_mid  (tick_mid),
    .strb_high (tick_high)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    range_q <= '0;
    else if (freq_load) range_q <= freq_byte;
  end
  assign range_code = range_q;
endmodule

// File: rtl/scl_period_chk.sv
module scl_period_chk
  import scl_gen_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              hold,
  input phase_e            phase,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cur_low,
  input logic              drive_low,
  input logic              t_low,
  input logic              t_mid,
  input logic              t_high,
  input logic              f_load,
  input logic [BYTE_W-1:0] f_byte,
  input logic [BYTE_W-1:0] r_code
);
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drive_low && !t_low && !t_mid && !t_high)); // R4
  AST_LOW_EDGE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> t_low); // R5
  AST_HIGH_TICK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    t_high |-> (!drive_low && $past(drive_low))); // R5
  AST_MID_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    t_mid |-> drive_low); // R6
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hold && phase == PH_HIGH) |=> (phase == PH_HIGH && $stable(cnt))); // R7
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOW && !t_low) |-> $stable(cur_low)); // R8
  AST_RANGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    f_load |=> (r_code == $past(f_byte))); // R9
endmodule

bind scl_period_gen scl_period_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (ctl_byte[EN_BIT]),
  .hold      (hold_in),
  .phase     (phase_w),
  .cnt       (cnt_w),
  .cur_low   (cur_low_w),
  .drive_low (scl_drive_low),
  .t_low     (tick_low),
  .t_mid     (tick_mid),
  .t_high    (tick_high),
  .f_load    (freq_load),
  .f_byte    (freq_byte),
  .r_code    (range_code)
);

// File: tb/sim_scl_period_gen.sv
`timescale 1ns/1ps
module sim_scl_period_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctl_byte = 8'h00;
  logic [7:0] ext_byte = 8'h00;
  logic [7:0] freq_byte = 8'h00;
  logic       freq_load = 1'b0;
  logic       hold_in = 1'b0;
  logic       scl_drive_low, tick_low, tick_mid, tick_high;
  logic [7:0] range_code;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scl_period_gen u0 (
    .clk(clk), .rst_n(rst_n), .ctl_byte(ctl_byte), .ext_byte(ext_byte),
    .freq_byte(freq_byte), .freq_load(freq_load), .hold_in(hold_in),
    .scl_drive_low(scl_drive_low), .tick_low(tick_low), .tick_mid(tick_mid),
    .tick_high(tick_high), .range_code(range_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait at negedges until a low phase starts.
  task automatic find_start(input string req);
    int n = 0;
    @(negedge clk);
    while (!tick_low && n < 10000) begin
      n++;
      @(negedge clk);
    end
    chk({req, " start found"}, int'(tick_low), 1);
  endtask

  // Called on a tick_low negedge; returns at the next tick_low negedge.
  task automatic measure(output int lo, output int hi, output int mid, output int th);
    lo = 0; hi = 0; mid = -1; th = -1;
    while (scl_drive_low && lo < 10000) begin
      if (tick_mid) mid = lo;
      lo++;
      @(negedge clk);
    end
    while (!tick_low && hi < 10000) begin
      if (tick_high) th = hi;
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input bit fast, input int div);
    @(negedge clk);
    ctl_byte = 8'h00;
    repeat (3) @(negedge clk);
    ext_byte = 8'(div >> 5);
    ctl_byte = {1'b0, fast, 1'b1, 5'(div)};
  endtask

  task automatic run_case(input string req, input bit fast, input int div);
    int n, lo, hi, mid, th, exp_lo, exp_hi;
    n = div + 1;
    exp_lo = fast ? n : n + 1;
    exp_hi = fast ? (n + 1) / 2 + 2 : n + 1;
    set_cfg(fast, div);
    find_start(req);
    measure(lo, hi, mid, th);
    chk({req, " low length"}, lo, exp_lo);
    chk({req, " high length"}, hi, exp_hi);
    chk({"R6 mid position ", req}, mid, exp_lo / 2);
    chk({"R5 high tick ", req}, th, 0);
  endtask

  task automatic test_reset;
    chk("R5 reset drive", int'(scl_drive_low), 0);
    chk("R5 reset ticks", int'(tick_low | tick_mid | tick_high), 0);
    chk("R9 reset range", int'(range_code), 0);
  endtask

  task automatic test_first_period;
    int n = 0;
    @(negedge clk);
    ctl_byte = 8'h23;
    @(negedge clk);
    n++;
    while (!tick_low && n < 50) begin n++; @(negedge clk); end
    chk("R5 start latency", n, 1);
    ctl_byte = 8'h00;
  endtask

  task automatic test_disable;
    int bad = 0;
    run_case("R2 pre-disable", 1'b0, 3);
    @(negedge clk);
    ctl_byte[5] = 1'b0;
    @(negedge clk);
    repeat (40) begin
      if (scl_drive_low || tick_low || tick_mid || tick_high) bad++;
      @(negedge clk);
    end
    chk("R4 idle while disabled", bad, 0);
  endtask

  task automatic test_hold;
    int hi = 0;
    set_cfg(1'b0, 3);
    find_start("R7");
    while (scl_drive_low) @(negedge clk);
    while (!tick_low && hi < 1000) begin
      hold_in = (hi < 4);
      hi++;
      @(negedge clk);
    end
    hold_in = 1'b0;
    chk("R7 held high length", hi, 9);
  endtask

  task automatic test_change;
    int lo, hi, mid, th;
    set_cfg(1'b0, 3);
    find_start("R8");
    ctl_byte = 8'h29;
    measure(lo, hi, mid, th);
    chk("R8 current low kept", lo, 5);
    chk("R8 current high kept", hi, 5);
    measure(lo, hi, mid, th);
    chk("R8 next low", lo, 11);
    chk("R8 next high", hi, 11);
  endtask

  task automatic test_range;
    @(negedge clk);
    freq_byte = 8'd4; freq_load = 1'b1;
    @(negedge clk);
    freq_load = 1'b0; freq_byte = 8'd9;
    chk("R9 range loaded", int'(range_code), 4);
    repeat (3) @(negedge clk);
    chk("R9 range held", int'(range_code), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_first_period();
    run_case("R2 std div3", 1'b0, 3);
    run_case("R1 R2 std split div", 1'b0, 37);
    run_case("R3 fast div4", 1'b1, 4);
    run_case("R3 fast div5", 1'b1, 5);
    run_case("R3 fast div0", 1'b1, 0);
    run_case("R1 R3 fast max div", 1'b1, 2047);
    test_disable();
    test_hold();
    test_change();
    test_range();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule